// File: doc/BRIEF.md
# Multiplexed-Bus DMA Master Engine

This block carries out word or byte DMA transfers for an internal requester over a multiplexed system bus. The bus has 24 address bits: the top eight bits sit on their own output, and the low sixteen share the data lines during a short address phase. The requester loads a start address, a direction and a transfer count with a one-clock start pulse. The engine then asks for the bus with an active-low request and waits for the active-low grant. It runs one transfer after another, each with an address phase and a data phase. Every transfer is stretched until the addressed memory answers with an active-low READY. The engine hands the bus back when the burst ends.

Two pin personalities are selectable. In the first, two pins carry a byte-lane mask. In the second, one pin flags a byte transfer and the other passes the grant down a daisy chain. The address-strobe polarity is also selectable. The burst length can be one transfer, eight transfers or unlimited, and an external release input can cut a burst short. When a burst ends before the work is finished, the engine releases the bus, waits for the grant to drop, and asks again for the transfers that remain.

Top module: `mux_dma_master`

## Requirements
- R1: After reset the bus request is high, the drive enable, busy and done are low, and the data strobe is high.
- R2: With work pending, the request goes low only while the grant input is high. It stays low until the engine releases the bus. The engine becomes master in the clock after it samples the grant low while its request is low.
- R3: Each transfer begins with two address-phase clocks. In these clocks the upper output carries address bits 23:16, the data lines carry bits 15:0, and the address strobe is active. The strobe pin is high when active with polarity select 0 and low when active with polarity select 1.
- R4: In the data phase the data strobe is low. A write keeps the data-out control high for the whole transfer and puts the requester's write data on the data lines. A read raises the data-out control only in the address phase and raises the data-in control only in the data phase. The read flag is high for the whole of a read transfer.
- R5: A transfer lasts at least 6 clocks. It ends in the first clock, from the sixth on, in which READY low has passed through a two-flop synchroniser. The acknowledge pulses in that clock, and during a read it presents the bus data as read data.
- R6: A burst-limit field of 0 allows 1 transfer per grant, 1 allows 8, and 2 or 3 allow no limit. When a limited burst ends with work left, the engine releases the request, waits for the grant to go high, then requests again.
- R7: If the release input is seen high at any clock of a transfer, the bus is released after that transfer completes.
- R8: The address advances by 2 after each word transfer and by 1 after each byte transfer when byte mode is set. The carry crosses into the upper address bits.
- R9: In mask personality (select 0), the pin pair {mask1, mask0} reads 00 for a word, 01 for the upper byte (odd address) and 10 for the lower byte (even address).
- R10: In chained personality (select 1), the first pin is high for a byte transfer and low for a word. The byte lane is given by address bit 0 on the data lines.
- R11: In chained personality, the second pin is low exactly when the grant is low and this engine's request is high.
- R12: Outside master ownership the drive enable is low, the data strobe is high and both transceiver controls are low. Done pulses for one clock once the last transfer is complete and the grant has gone high again. Busy is high from start until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_busrq_mode | input | 1 | 0: byte-mask personality, 1: byte-flag with chained grant |
| cfg_as_low | input | 1 | Address-strobe polarity, 1 = active low |
| cfg_burst | input | 2 | Burst limit: 0 = 1, 1 = 8, 2/3 = unlimited |
| cfg_byte_mode | input | 1 | Byte transfers instead of words |
| req_start | input | 1 | Start pulse, taken while idle |
| req_write | input | 1 | 1 = write to memory |
| req_addr | input | 24 | Start address |
| req_len | input | 16 | Number of transfers, nonzero |
| req_wdata | input | 16 | Write data for the current transfer |
| req_busy | output | 1 | Job in progress |
| xfer_ack | output | 1 | Transfer completes this clock |
| rd_data | output | 16 | Read data, valid with acknowledge on reads |
| done | output | 1 | One-clock job completion pulse |
| bus_req_n | output | 1 | Active-low bus request |
| hlda_n | input | 1 | Active-low bus grant |
| busrel | input | 1 | Host request to end the burst |
| ready_n | input | 1 | Active-low asynchronous memory ready |
| mst_oe | output | 1 | Drive enable for all three-state bus outputs |
| hi_addr | output | 8 | Address bits 23:16 |
| dal_o | output | 16 | Multiplexed address/data out |
| dal_oe | output | 1 | Drive enable for the data lines |
| dal_i | input | 16 | Multiplexed data in |
| astb | output | 1 | Address strobe, polarity per cfg_as_low |
| das_n | output | 1 | Active-low data strobe |
| dali | output | 1 | Transceiver data-in control |
| dalo | output | 1 | Transceiver data-out control |
| read_o | output | 1 | High for a read transfer |
| pin_bm0_byte | output | 1 | Mask bit 0, or byte flag |
| pin_bm1_busako | output | 1 | Mask bit 1, or chained grant out |

## Verification
The hardest state to reach is the chained grant: the engine must have work pending while a different master holds the grant, so that the engine's request has to stay high and the chain output has to pass the grant on. The bench arbiter has a flag that holds the grant low for a foreign master. A job is started while that flag is set, and the flag is then cleared so that the engine can claim the bus. A release pulse timed to the first master clock, a burst of 10 against a limit of 8, and a byte run that carries from address bits 15:0 into bits 23:16 cover the other corners.

// File: rtl/mux_dma_master.sv
module mux_dma_master #(
  parameter int AW         = 24,
  parameter int DW         = 16,
  parameter int LW         = 16,
  parameter int MIN_CYC    = 6,
  parameter int ADDR_CLKS  = 2,
  parameter int LONG_BURST = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_busrq_mode,
  input  logic          cfg_as_low,
  input  logic [1:0]    cfg_burst,
  input  logic          cfg_byte_mode,
  input  logic          req_start,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [DW-1:0] req_wdata,
  output logic          req_busy,
  output logic          xfer_ack,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          bus_req_n,
  input  logic          hlda_n,
  input  logic          busrel,
  input  logic          ready_n,
  output logic          mst_oe,
  output logic [AW-DW-1:0] hi_addr,
  output logic [DW-1:0] dal_o,
  output logic          dal_oe,
  input  logic [DW-1:0] dal_i,
  output logic          astb,
  output logic          das_n,
  output logic          dali,
  output logic          dalo,
  output logic          read_o,
  output logic          pin_bm0_byte,
  output logic          pin_bm1_busako
);

  localparam int CW = $clog2(MIN_CYC);
  localparam int BW = $clog2(LONG_BURST + 1);
  localparam logic [CW-1:0] CYC_LAST = CW'(MIN_CYC - 1);
  localparam logic [CW-1:0] ADR_END  = CW'(ADDR_CLKS);
  localparam logic [BW-1:0] BEAT_END = BW'(LONG_BURST - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER, S_REL} st_t;

  st_t           st;
  logic [CW-1:0] cyc;
  logic [LW-1:0] rem;
  logic [AW-1:0] addr;
  logic [BW-1:0] beat;
  logic          wr, rel_pend, rdy1, rdy2;

  logic          xfer, aph, end_x, lim_hit, ale;
  logic [AW-1:0] step;

  assign xfer    = (st == S_XFER);
  assign aph     = (cyc < ADR_END);
  assign end_x   = xfer && (cyc == CYC_LAST) && rdy2;
  assign lim_hit = (cfg_burst == 2'b00) || (cfg_burst == 2'b01 && beat == BEAT_END);
  assign step    = cfg_byte_mode ? AW'(1) : AW'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cyc       <= '0;
      rem       <= '0;
      addr      <= '0;
      beat      <= '0;
      wr        <= 1'b0;
      rel_pend  <= 1'b0;
      rdy1      <= 1'b0;
      rdy2      <= 1'b0;
      bus_req_n <= 1'b1;
      done      <= 1'b0;
    end else begin
      rdy1 <= ~ready_n;
      rdy2 <= rdy1;
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_start) begin
          addr <= req_addr;
          rem  <= req_len;
          wr   <= req_write;
          st   <= S_REQ;
        end
        S_REQ: begin
          if (bus_req_n && hlda_n) bus_req_n <= 1'b0;
          else if (!bus_req_n && !hlda_n) begin
            st       <= S_XFER;
            cyc      <= '0;
            beat     <= '0;
            rel_pend <= 1'b0;
          end
        end
        S_XFER: begin
          if (busrel) rel_pend <= 1'b1;
          if (end_x) begin
            rem  <= rem - LW'(1);
            addr <= addr + step;
            beat <= beat + BW'(1);
            if (rem == LW'(1) || lim_hit || rel_pend || busrel) begin
              st        <= S_REL;
              bus_req_n <= 1'b1;
            end else begin
              cyc <= '0;
            end
          end else if (cyc != CYC_LAST) begin
            cyc <= cyc + CW'(1);
          end
        end
        default: if (hlda_n) begin
          if (rem == '0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st <= S_REQ;
          end
        end
      endcase
    end
  end

  assign req_busy = (st != S_IDLE);
  assign xfer_ack = end_x;
  assign rd_data  = dal_i;
  assign mst_oe   = xfer;
  assign hi_addr  = addr[AW-1:DW];
  assign ale      = xfer && aph;
  assign astb     = ale ^ cfg_as_low;
  assign das_n    = ~(xfer && !aph);
  assign dalo     = xfer && (wr || aph);
  assign dali     = xfer && !wr && !aph;
  assign dal_oe   = dalo;
  assign read_o   = xfer && !wr;
  assign dal_o    = aph ? addr[DW-1:0] : req_wdata;

  assign pin_bm0_byte   = cfg_busrq_mode ? (xfer && cfg_byte_mode)
                                         : (xfer && cfg_byte_mode && addr[0]);
  assign pin_bm1_busako = cfg_busrq_mode ? ~(!hlda_n && bus_req_n)
                                         : (xfer && cfg_byte_mode && !addr[0]);

endmodule

// File: rtl/mux_dma_master_chk.sv
module mux_dma_master_chk #(
  parameter int MIN_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_busrq_mode,
  input logic cfg_as_low,
  input logic hlda_n,
  input logic bus_req_n,
  input logic mst_oe,
  input logic astb,
  input logic das_n,
  input logic dali,
  input logic dalo,
  input logic xfer_ack,
  input logic pin_bm0_byte,
  input logic pin_bm1_busako,
  input logic done
);

  logic       ale, ale_q;
  logic [7:0] since_adr;

  assign ale = mst_oe && (astb ^ cfg_as_low);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_q     <= 1'b0;
      since_adr <= '0;
    end else begin
      ale_q <= ale;
      if (ale && !ale_q) since_adr <= 8'd1;
      else if (since_adr != 8'hFF) since_adr <= since_adr + 8'd1;
    end
  end

  p_req_held_while_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mst_oe |-> !bus_req_n);
  p_master_only_granted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mst_oe |-> !hlda_n);
  p_strobe_not_with_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> das_n);
  p_xcvr_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dali && dalo));
  p_min_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> (since_adr >= 8'(MIN_CYC - 1)) && !ale);
  p_mask_none_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_busrq_mode && mst_oe) |-> !(pin_bm0_byte && pin_bm1_busako));
  p_chain_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_busrq_mode && !hlda_n && bus_req_n) |-> !pin_bm1_busako);
  p_done_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_req_n && !mst_oe));
  p_idle_strobes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_oe |-> (das_n && !dali && !dalo));

endmodule

bind mux_dma_master mux_dma_master_chk #(.MIN_CYC(MIN_CYC)) u_chk (.*);

// File: tb/tb_mux_dma_master.sv
module tb_mux_dma_master;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_busrq_mode = 1'b0, cfg_as_low = 1'b0, cfg_byte_mode = 1'b0;
  logic [1:0]  cfg_burst = 2'd2;
  logic        req_start = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [15:0] req_wdata;
  logic        req_busy, xfer_ack, done, bus_req_n, mst_oe, dal_oe;
  logic [15:0] rd_data, dal_o, dal_i;
  logic        hlda_n = 1'b1, busrel = 1'b0, ready_n = 1'b1;
  logic [7:0]  hi_addr;
  logic        astb, das_n, dali, dalo, read_o, pin_bm0_byte, pin_bm1_busako;

  mux_dma_master dut (.*);

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] wpat(input int i);
    return 16'hC000 ^ 16'(i * 16'h0123);
  endfunction
  function automatic logic [15:0] spat(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C ^ {8'h00, a[23:16]};
  endfunction

  // memory slave, arbiter, requester
  logic [23:0] slv_a = '0;
  int wait_n = 0, dcnt = 0, widx = 0;
  bit other_busy = 0;
  assign dal_i     = spat(slv_a);
  assign req_wdata = wpat(widx);

  always @(posedge clk) begin
    if (mst_oe && (astb ^ cfg_as_low)) slv_a <= {hi_addr, dal_o};
    if (mst_oe && !das_n) dcnt <= dcnt + 1; else dcnt <= 0;
    ready_n <= !(mst_oe && !das_n && dcnt >= wait_n);
    hlda_n  <= other_busy ? 1'b0 : bus_req_n;
    if (xfer_ack && !read_o) widx <= widx + 1;
  end

  // behavioural reference model
  int m_st = 0, m_cyc = 0, m_rem = 0, m_beat = 0, m_idx = 0;
  bit m_req = 1, m_wr = 0, m_rel = 0, m_r1 = 0, m_r2 = 0, m_done = 0;
  logic [23:0] m_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_req = 1; m_r1 = 0; m_r2 = 0; m_done = 0; m_cyc = 0;
    end else begin
      bit fin, nr;
      int lim;
      fin = (m_st == 2) && (m_cyc >= 5) && m_r2;
      nr = !ready_n;
      lim = (cfg_burst == 0) ? 1 : (cfg_burst == 1) ? 8 : 0;
      m_done = 0;
      case (m_st)
        0: if (req_start) begin
          m_addr = req_addr; m_rem = int'(req_len); m_wr = req_write; m_st = 1;
        end
        1: begin
          if (m_req && hlda_n) m_req = 0;
          else if (!m_req && !hlda_n) begin
            m_st = 2; m_cyc = 0; m_beat = 0; m_rel = 0;
          end
        end
        2: begin
          if (busrel) m_rel = 1;
          if (fin) begin
            m_rem--; m_beat++;
            m_addr = m_addr + (cfg_byte_mode ? 24'd1 : 24'd2);
            if (m_wr) m_idx++;
            if (m_rem == 0 || (lim != 0 && m_beat == lim) || m_rel) begin
              m_st = 3; m_req = 1;
            end else m_cyc = 0;
          end else m_cyc++;
        end
        default: if (hlda_n) begin
          if (m_rem == 0) begin m_st = 0; m_done = 1; end
          else m_st = 1;
        end
      endcase
      m_r2 = m_r1; m_r1 = nr;
    end
  end

  // per-clock comparison, away from the active edge
  int gcnt = 0, mcnt = 0;
  bit prev_req = 1;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit x, ap, ack;
      x = (m_st == 2);
      ap = (m_cyc < 2);
      ack = x && (m_cyc >= 5) && m_r2;
      chk(bus_req_n == m_req, "R2 request level", bus_req_n, m_req);
      chk(mst_oe == x, "R12 master enable", mst_oe, x);
      chk(req_busy == (m_st != 0), "R12 busy", req_busy, m_st != 0);
      chk(done == m_done, "R12 done pulse", done, m_done);
      if (x) begin
        chk(astb == (ap ^ cfg_as_low), "R3 address strobe", astb, ap ^ cfg_as_low);
        chk(hi_addr == m_addr[23:16], "R3 upper address", hi_addr, m_addr[23:16]);
        if (ap) chk(dal_o == m_addr[15:0], "R3 muxed address", dal_o, m_addr[15:0]);
        else if (m_wr) chk(dal_o == wpat(m_idx), "R4 write data", dal_o, wpat(m_idx));
        chk(das_n == ap, "R4 data strobe", das_n, ap);
        chk(dalo == (m_wr || ap), "R4 data-out control", dalo, m_wr || ap);
        chk(dali == (!m_wr && !ap), "R4 data-in control", dali, !m_wr && !ap);
        chk(read_o == !m_wr, "R4 read flag", read_o, !m_wr);
        if (!cfg_busrq_mode) begin
          chk(pin_bm0_byte == (cfg_byte_mode && m_addr[0]), "R9 mask bit0",
              pin_bm0_byte, cfg_byte_mode && m_addr[0]);
          chk(pin_bm1_busako == (cfg_byte_mode && !m_addr[0]), "R9 mask bit1",
              pin_bm1_busako, cfg_byte_mode && !m_addr[0]);
        end else begin
          chk(pin_bm0_byte == cfg_byte_mode, "R10 byte flag", pin_bm0_byte, cfg_byte_mode);
        end
      end else begin
        chk(das_n && !dali && !dalo, "R12 idle strobes", {das_n, dali, dalo}, 3'b100);
      end
      if (cfg_busrq_mode)
        chk(pin_bm1_busako == !(!hlda_n && m_req), "R11 chained grant",
            pin_bm1_busako, !(!hlda_n && m_req));
      chk(xfer_ack == ack, "R5 transfer end", xfer_ack, ack);
      if (ack && !m_wr) chk(rd_data == spat(m_addr), "R5 read data", rd_data, spat(m_addr));
      if (prev_req && !bus_req_n) gcnt++;
      if (mst_oe) mcnt++;
    end
    prev_req = bus_req_n;
  end

  task automatic job(input bit wr, input logic [23:0] a, input int len, input int wt,
                     input bit relp, input int exp_g, input string tag);
    int g0, c0, step;
    bit seen, sent;
    step = cfg_byte_mode ? 1 : 2;
    wait_n = wt;
    g0 = gcnt; c0 = mcnt; seen = 0; sent = 0;
    @(negedge clk);
    req_write = wr; req_addr = a; req_len = 16'(len); req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      if (busrel) busrel = 1'b0;
      if (relp && !sent && mst_oe) begin busrel = 1'b1; sent = 1; end
      if (done) seen = 1;
    end
    #2;
    chk(seen, {tag, " job completes"}, seen, 1);
    chk(gcnt - g0 == exp_g, {tag, " grant count"}, gcnt - g0, exp_g);
    chk(mcnt - c0 == len * (6 + wt), "R5 master clocks", mcnt - c0, len * (6 + wt));
    chk(slv_a == a + 24'((len - 1) * step), "R8 last address", slv_a, a + 24'((len - 1) * step));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(bus_req_n && !mst_oe && !req_busy && das_n && !done, "R1 reset state",
        {bus_req_n, mst_oe, req_busy, das_n, done}, 5'b10010);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    job(1, 24'h123400, 3, 0, 0, 1, "R2 word write");            // min-length cycles
    job(0, 24'hAB0010, 2, 3, 0, 1, "R2 stretched read");       // READY late
    cfg_burst = 2'd0;
    job(1, 24'h005000, 3, 0, 0, 3, "R6 single-transfer burst");
    cfg_burst = 2'd1;
    job(0, 24'h0100F0, 10, 0, 0, 2, "R6 eight-transfer burst");
    cfg_burst = 2'd2;
    job(1, 24'h020000, 4, 0, 1, 2, "R7 release input");
    cfg_byte_mode = 1'b1;
    job(0, 24'h000101, 3, 0, 0, 1, "R9 byte masks");
    cfg_busrq_mode = 1'b1; cfg_as_low = 1'b1;
    job(1, 24'h7FFFFE, 3, 1, 0, 1, "R10 byte flag carry R8");
    cfg_byte_mode = 1'b0;

    // R11: another master owns the bus while work is pending
    other_busy = 1;
    repeat (3) @(negedge clk);
    req_write = 1'b0; req_addr = 24'h300000; req_len = 16'd1; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    repeat (4) @(negedge clk);
    #2;
    chk(!pin_bm1_busako, "R11 grant passed on", pin_bm1_busako, 0);
    chk(bus_req_n && req_busy, "R2 no request while foreign grant", bus_req_n, 1);
    @(negedge clk);
    other_busy = 0;
    begin
      bit seen = 0;
      for (int i = 0; i < 2000 && !seen; i++) begin
        @(negedge clk);
        if (done) seen = 1;
      end
      chk(seen, "R11 job after foreign release", seen, 1);
    end
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    checks++; errors++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule